// File: doc/BRIEF.md
# Program Image Checksum Accumulator

This block forms the 16-bit checksum of a program-memory image while the image's words are streamed into it one per cycle. The words may come from a stored image or from device read-back. A run opens with a start pulse and closes with a finish pulse. Between the two, each valid word whose address lies within user program space is added to a 16-bit running total. At finish, the configuration word is masked to 14 bits and added. When code protection is set, a word packed from the four ID nibbles is added as well. The result is held on `sum_o`, and `done_o` pulses for one cycle.

The rule depends on the code-protect setting. With protection off, the checksum covers program memory plus the masked configuration word. With protection on, program memory is left out, and the total is the masked configuration word plus the packed ID word. The highest user address is a parameter, so the same block serves both the 512-word and the 1K-word memory sizes.

Top module: `csum_engine`

## Requirements
- R1: After reset, `sum_o` is 0 and `done_o` is 0.
- R2: A start pulse sets `sum_o` to 0 on the next clock and samples `cp_on_i` for the whole run. Start takes priority over a finish presented in the same cycle; that finish is dropped and gives no `done_o`.
- R3: With protection off, every valid word with address at most `LAST_ADDR` is added to the total, zero-extended from 14 bits. Carries beyond bit 15 are discarded.
- R4: Words whose address is above `LAST_ADDR` are ignored, including configuration-space addresses such as 2000h.
- R5: With protection on (as sampled at start), streamed words are ignored.
- R6: Finish adds `cfg_word_i & 3FFFh`. If protection is on, it also adds the packed ID word, formed as follows. ID location k sits in `id_words_i[14k+13:14k]`. Its low nibble is placed in bits [15-4k:12-4k], so ID0 is the most significant nibble and IDs 1, 2, 3, 4 give 1234h.
- R7: `done_o` is high for exactly the one cycle after a finish is accepted. `sum_o` then holds the final value until the next start.
- R8: Words and finish pulses outside an open run (before any start, or after finish) change neither `sum_o` nor `done_o`.
- R9: For a blank 1K-word image with protection off, the result is 3BFFh. Such an image has 400h words of 3FFFh at addresses 0 to 3FFh and a configuration word of 3FFFh.
- R10: A valid word presented in the same cycle as finish is still counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a run and clears the total |
| finish_i | input | 1 | Closes the run and adds the final terms |
| cp_on_i | input | 1 | Code protection set; sampled at start |
| word_vld_i | input | 1 | Word strobe |
| word_i | input | 14 | Program word |
| addr_i | input | 14 | Address of the word |
| cfg_word_i | input | 16 | Configuration word (masked to 14 bits) |
| id_words_i | input | 56 | Four ID locations, ID0 in the low 14 bits |
| sum_o | output | 16 | Checksum |
| done_o | output | 1 | One-cycle result pulse |

## Verification
The assertions assume that start and finish are single-cycle pulses. They also assume that the configuration and ID inputs are steady in the finish cycle. The stimulus drives every input half a cycle away from the capturing edge. It opens each run with exactly one start and closes it with exactly one finish, except for one deliberate start-and-finish collision. A behavioural model in the bench follows the same input stream and is compared with `sum_o` and `done_o` on every clock.

// File: rtl/csum_pkg.sv
package csum_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } csum_st_e;

  localparam int unsigned CFG_KEEP_W = 14;
endpackage

// File: rtl/csum_word_gate.sv
module csum_word_gate #(
  parameter int unsigned DATA_W    = 14,
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned SUM_W     = 16,
  parameter int unsigned LAST_ADDR = 32'h3FF
) (
  input  logic              vld_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              run_i,
  input  logic              cp_i,
  output logic [SUM_W-1:0]  term_o
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

  logic take;
  assign take = vld_i && run_i && !cp_i && (addr_i <= LAST_A);

  always_comb begin
    term_o = '0;
    if (take) term_o[DATA_W-1:0] = word_i;
  end
endmodule

// File: rtl/csum_id_pack.sv
module csum_id_pack #(
  parameter int unsigned ID_NUM = 4,
  parameter int unsigned DATA_W = 14,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned PACK_W = ID_NUM * NIB_W
) (
  input  logic [ID_NUM*DATA_W-1:0] id_words_i,
  output logic [PACK_W-1:0]        packed_o
);
  // first ID lands in the most significant nibble
  for (genvar g = 0; g < ID_NUM; g++) begin : g_nib
    assign packed_o[(ID_NUM-1-g)*NIB_W +: NIB_W] = id_words_i[g*DATA_W +: NIB_W];
  end
endmodule

// File: rtl/csum_acc.sv
module csum_acc
  import csum_pkg::*;
#(
  parameter int unsigned SUM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             finish_i,
  input  logic             cp_i,
  input  logic [SUM_W-1:0] word_term_i,
  input  logic [SUM_W-1:0] fin_term_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             done_o,
  output logic             run_o,
  output logic             cp_q_o
);
  csum_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sum_o  <= '0;
      done_o <= 1'b0;
      cp_q_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        st_q   <= ST_RUN;
        sum_o  <= '0;
        cp_q_o <= cp_i;
      end else if (st_q == ST_RUN) begin
        sum_o <= sum_o + word_term_i + (finish_i ? fin_term_i : '0);
        if (finish_i) begin
          st_q   <= ST_IDLE;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign run_o = (st_q == ST_RUN);

  // R2
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (sum_o == '0) && !done_o);

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_after_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(finish_i && run_o && !start_i));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !start_i) |=> $stable(sum_o) && !done_o);
endmodule

// File: rtl/csum_engine.sv
module csum_engine
  import csum_pkg::*;
#(
  parameter int unsigned DATA_W    = 14,
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned SUM_W     = 16,
  parameter int unsigned ID_NUM    = 4,
  parameter int unsigned NIB_W     = 4,
  parameter int unsigned LAST_ADDR = 32'h3FF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     finish_i,
  input  logic                     cp_on_i,
  input  logic                     word_vld_i,
  input  logic [DATA_W-1:0]        word_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [SUM_W-1:0]         cfg_word_i,
  input  logic [ID_NUM*DATA_W-1:0] id_words_i,
  output logic [SUM_W-1:0]         sum_o,
  output logic                     done_o
);
  localparam int unsigned PACK_W = ID_NUM * NIB_W;
  localparam logic [SUM_W-1:0] CFG_MASK = SUM_W'((1 << CFG_KEEP_W) - 1);

  logic             run, cp_q;
  logic [SUM_W-1:0] word_term, fin_term, id_term;
  logic [PACK_W-1:0] id_pack;

  csum_word_gate #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SUM_W(SUM_W), .LAST_ADDR(LAST_ADDR)
  ) u_gate (
    .vld_i (word_vld_i),
    .word_i(word_i),
    .addr_i(addr_i),
    .run_i (run),
    .cp_i  (cp_q),
    .term_o(word_term)
  );

  csum_id_pack #(
    .ID_NUM(ID_NUM), .DATA_W(DATA_W), .NIB_W(NIB_W)
  ) u_pack (
    .id_words_i(id_words_i),
    .packed_o  (id_pack)
  );

  always_comb begin
    id_term = '0;
    id_term[PACK_W-1:0] = id_pack;
  end

  assign fin_term = (cfg_word_i & CFG_MASK) + (cp_q ? id_term : '0);

  csum_acc #(.SUM_W(SUM_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .finish_i   (finish_i),
    .cp_i       (cp_on_i),
    .word_term_i(word_term),
    .fin_term_i (fin_term),
    .sum_o      (sum_o),
    .done_o     (done_o),
    .run_o      (run),
    .cp_q_o     (cp_q)
  );

  // R5
  cp_words_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cp_q && !start_i && !finish_i) |=> $stable(sum_o));

  // R4
  high_addr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !start_i && !finish_i && word_vld_i && (addr_i > ADDR_W'(LAST_ADDR)))
      |=> $stable(sum_o));

  // R3
  word_added_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !cp_q && !start_i && !finish_i && word_vld_i && (addr_i <= ADDR_W'(LAST_ADDR)))
      |=> (sum_o == SUM_W'($past(sum_o) + SUM_W'($past(word_i)))));
endmodule

// File: tb/csum_engine_tb.sv
module csum_engine_tb;
  localparam int LAST = 'h3FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0, finish = 0, cp_on = 0, vld = 0;
  logic [13:0] word = '0, addr = '0;
  logic [15:0] cfg = '0;
  logic [55:0] ids = '0;
  logic [15:0] sum;
  logic        done;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  csum_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .finish_i(finish),
    .cp_on_i(cp_on), .word_vld_i(vld), .word_i(word), .addr_i(addr),
    .cfg_word_i(cfg), .id_words_i(ids), .sum_o(sum), .done_o(done)
  );

  // behavioural reference
  int  m_sum = 0;
  bit  m_run = 0, m_cp = 0, m_done = 0;

  function automatic int pack_ids(logic [55:0] v);
    int p = 0;
    for (int k = 0; k < 4; k++) p = (p << 4) | int'(v[k*14 +: 4]);
    return p;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      int add;
      m_done <= 0;
      if (start) begin
        m_sum <= 0; m_run <= 1; m_cp <= cp_on;
      end else if (m_run) begin
        add = (vld && !m_cp && int'(addr) <= LAST) ? int'(word) : 0;
        if (finish) begin
          add += int'(cfg) & 'h3FFF;
          if (m_cp) add += pack_ids(ids);
          m_done <= 1; m_run <= 0;
        end
        m_sum <= (m_sum + add) & 'hFFFF;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(int'(sum) == m_sum, "R3 model sum", int'(sum), m_sum);
    chk(done == m_done, "R7 model done", int'(done), int'(m_done));
  end

  task automatic cyc(bit st, bit fi, bit v, logic [13:0] w, logic [13:0] a);
    start = st; finish = fi; vld = v; word = w; addr = a;
    @(negedge clk);
    start = 0; finish = 0; vld = 0;
  endtask

  function automatic logic [55:0] mk_ids(int a, int b, int c, int d);
    logic [55:0] r;
    r[13:0]  = 14'(a); r[27:14] = 14'(b);
    r[41:28] = 14'(c); r[55:42] = 14'(d);
    return r;
  endfunction

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(sum == 0 && done == 0, "R1 reset", int'(sum), 0);
    rst_n = 1;
    @(negedge clk);
    // R8: word and finish before any start
    cyc(0, 0, 1, 14'h123, 14'h1);
    cyc(0, 1, 0, 0, 0);
    chk(sum == 0 && done == 0, "R8 before start", int'(sum), 0);

    // R3 R6 R7
    cfg = 16'hFFFF; ids = mk_ids('h3FF1, 'h3FF2, 'h3FF3, 'h3FF4);
    cyc(1, 0, 0, 0, 0);
    chk(sum == 0, "R2 cleared", int'(sum), 0);
    cyc(0, 0, 1, 14'h0011, 14'h0);
    cyc(0, 0, 1, 14'h0022, 14'h5);
    chk(sum == 16'h0033, "R3 words", int'(sum), 'h33);
    cyc(0, 1, 0, 0, 0);
    chk(sum == 16'h4032, "R6 cfg mask", int'(sum), 'h4032);
    chk(done == 1, "R7 done high", int'(done), 1);
    cyc(0, 0, 0, 0, 0);
    chk(done == 0 && sum == 16'h4032, "R7 done drop/hold", int'(done), 0);
    // R8 after finish
    cyc(0, 0, 1, 14'h0100, 14'h2);
    cyc(0, 1, 0, 0, 0);
    chk(sum == 16'h4032 && done == 0, "R8 after finish", int'(sum), 'h4032);

    // R4
    cfg = 16'h0;
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 14'h0100, 14'(LAST));
    cyc(0, 0, 1, 14'h0200, 14'(LAST + 1));
    cyc(0, 0, 1, 14'h0400, 14'h2000);
    chk(sum == 16'h0100, "R4 high addr", int'(sum), 'h100);
    cyc(0, 1, 0, 0, 0);

    // R5 R6 ID packing
    cp_on = 1; cfg = 16'h000F;
    cyc(1, 0, 0, 0, 0);
    cp_on = 0;
    cyc(0, 0, 1, 14'h0777, 14'h3);
    chk(sum == 0, "R5 cp words", int'(sum), 0);
    cyc(0, 1, 0, 0, 0);
    chk(sum == 16'h1243, "R6 id pack", int'(sum), 'h1243);

    // R2 cp sampled at start
    cyc(1, 0, 0, 0, 0);
    cp_on = 1;
    cyc(0, 0, 1, 14'h0009, 14'h4);
    chk(sum == 16'h0009, "R2 cp latched", int'(sum), 9);
    cp_on = 0;
    // R2 start beats finish
    cyc(1, 1, 1, 14'h0007, 14'h0);
    chk(sum == 0 && done == 0, "R2 start priority", int'(sum), 0);

    // R10
    cfg = 16'h0001;
    cyc(0, 1, 1, 14'h0005, 14'h1);
    chk(sum == 16'h0006, "R10 word with finish", int'(sum), 6);

    // R9 blank image with wrap
    cfg = 16'h3FFF;
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i <= LAST; i++) cyc(0, 0, 1, 14'h3FFF, 14'(i));
    cyc(0, 1, 0, 0, 0);
    chk(sum == 16'h3BFF, "R9 blank", int'(sum), 'h3BFF);

    cyc(0, 0, 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule